// File: doc/BRIEF.md
# Dual-Path Storage Bus Transceiver

This block joins two parallel data ports, side A and side B, with one storage path for each direction. Each path holds one storage element. While that path's latch enable is high the element is transparent. While the latch enable is low the element holds its value, except that a rising edge on the path's own clock loads the data present at its input. So the same hardware passes data straight through, freezes it, or registers it, and the choice is made at run time by the enables and the clocks.

Each side drives its pads through a data bus and a separate drive-enable signal, and the pad logic outside the block builds the three-state buffer. The A-to-B drive enable is active high. The B-to-A drive enable is active low. Storage is written whatever the drive enables are doing, so a word can be loaded while a bus is released and driven onto that bus later. An asynchronous active-low reset clears both storage elements to zero, so the outputs are known before the first load.

Top module: `xcvr_bidir`

## Requirements
- R1: While `rst_n` is low, both storage elements read zero. With both latch enables low, `b_o` and `a_o` are all zeros during reset and stay zero after reset is released until a new load.
- R2: While `le_ab` is 1, `b_o` equals `a_i` and follows every change of `a_i`.
- R3: While `le_ab` is 0 and `clk_ab` stays at one level (high or low), `b_o` keeps the stored word when `a_i` changes.
- R4: While `le_ab` is 0, a rising edge of `clk_ab` loads the present `a_i` into the A-to-B storage. A falling edge of `clk_ab` loads nothing.
- R5: A rising edge of `clk_ab` while `le_ab` is 1 has no effect of its own. The word present when `le_ab` falls is kept until the next rising edge of `clk_ab`.
- R6: The B-to-A path behaves as R2 to R5 do, using `le_ba`, `clk_ba`, `b_i` and `a_o`.
- R7: `b_oe` is 1 exactly when `oe_ab` is 1 (active high). When `b_oe` is 0 the B pads are high-impedance.
- R8: `a_oe` is 1 exactly when `oe_ba_n` is 0 (active low). When `a_oe` is 0 the A pads are high-impedance.
- R9: A load, whether transparent or clocked, updates the storage while the drive enable of that path is inactive. The loaded word appears once the drive enable becomes active again.
- R10: The controls and data of one direction do not change the output of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both storage elements |
| a_i | input | WIDTH | Data received from the A pads |
| a_o | output | WIDTH | Data to drive onto the A pads (B-to-A storage) |
| a_oe | output | 1 | Drive enable for the A pads |
| b_i | input | WIDTH | Data received from the B pads |
| b_o | output | WIDTH | Data to drive onto the B pads (A-to-B storage) |
| b_oe | output | 1 | Drive enable for the B pads |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| clk_ab | input | 1 | A-to-B load clock, rising edge |
| oe_ab | input | 1 | A-to-B drive enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| clk_ba | input | 1 | B-to-A load clock, rising edge |
| oe_ba_n | input | 1 | B-to-A drive enable, active low |

## Verification
At every edge of each path's own clock, the assertions check three things: the polarity of each drive enable, that the output equals the input while the path is transparent, and that the output holds the word taken at the previous rising edge when the latch enable has stayed low between the two edges. Some behaviour only the bench's scenarios can show, because it happens between clock edges or depends on order. This covers holding across input changes with the clock steady, a falling edge loading nothing, the word at the latch enable's falling edge surviving, loads made while the drive is released, the pads going high-impedance, and the two directions staying apart.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Polarity of a drive-enable pin
  typedef enum logic {
    OE_ACT_HIGH = 1'b0,
    OE_ACT_LOW  = 1'b1
  } oe_pol_e;

endpackage

// File: rtl/xcvr_path_store.sv
// One direction's storage: a level-sensitive latch merged with a
// rising-edge register. A flag records which of the two wrote last.
module xcvr_path_store #(
  parameter int WIDTH = 36
) (
  input  logic             rst_n,
  input  logic             le,
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] reg_next;
  logic             reg_owns;

  // Level-sensitive half: follows d while le is high
  always_latch begin
    if (!rst_n) begin
      lat_q = '0;
    end else if (le) begin
      lat_q = d;
    end
  end

  // Edge half: samples d on every rising edge; ownership decides use
  always_comb begin
    reg_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else begin
      reg_q <= reg_next;
    end
  end

  // Ownership: set by a rising edge with le low, cleared while le is high
  always_ff @(posedge clk or posedge le or negedge rst_n) begin
    if (!rst_n) begin
      reg_owns <= 1'b0;
    end else if (le) begin
      reg_owns <= 1'b0;
    end else begin
      reg_owns <= 1'b1;
    end
  end

  always_comb begin
    if (le) begin
      q = d;
    end else if (reg_owns) begin
      q = reg_q;
    end else begin
      q = lat_q;
    end
  end

endmodule

// File: rtl/xcvr_oe_stage.sv
module xcvr_oe_stage
  import xcvr_pkg::*;
#(
  parameter oe_pol_e POL = OE_ACT_HIGH
) (
  input  logic oe_pin,
  output logic drive_en
);

  generate
    if (POL == OE_ACT_LOW) begin : g_low
      assign drive_en = ~oe_pin;
    end else begin : g_high
      assign drive_en = oe_pin;
    end
  endgenerate

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe,
  input  logic             le_ab,
  input  logic             clk_ab,
  input  logic             oe_ab,
  input  logic             le_ba,
  input  logic             clk_ba,
  input  logic             oe_ba_n
);

  xcvr_path_store #(.WIDTH(WIDTH)) u_store_ab (
    .rst_n (rst_n),
    .le    (le_ab),
    .clk   (clk_ab),
    .d     (a_i),
    .q     (b_o)
  );

  xcvr_path_store #(.WIDTH(WIDTH)) u_store_ba (
    .rst_n (rst_n),
    .le    (le_ba),
    .clk   (clk_ba),
    .d     (b_i),
    .q     (a_o)
  );

  xcvr_oe_stage #(.POL(OE_ACT_HIGH)) u_oe_b (
    .oe_pin   (oe_ab),
    .drive_en (b_oe)
  );

  xcvr_oe_stage #(.POL(OE_ACT_LOW)) u_oe_a (
    .oe_pin   (oe_ba_n),
    .drive_en (a_oe)
  );

endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
  parameter int WIDTH = 36
) (
  input logic             rst_n,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe,
  input logic             le_ab,
  input logic             clk_ab,
  input logic             oe_ab,
  input logic             le_ba,
  input logic             clk_ba,
  input logic             oe_ba_n
);

  // Set once a rising edge happened with the latch enable low and it has
  // stayed low since; any high level on the latch enable disarms it.
  logic ab_armed;
  logic ba_armed;

  always_ff @(posedge clk_ab or posedge le_ab or negedge rst_n) begin
    if (!rst_n)     ab_armed <= 1'b0;
    else if (le_ab) ab_armed <= 1'b0;
    else            ab_armed <= 1'b1;
  end

  always_ff @(posedge clk_ba or posedge le_ba or negedge rst_n) begin
    if (!rst_n)     ba_armed <= 1'b0;
    else if (le_ba) ba_armed <= 1'b0;
    else            ba_armed <= 1'b1;
  end

  a_r2_ab_transparent: assert property (@(posedge clk_ab) disable iff (!rst_n)
    le_ab |-> (b_o == a_i));

  a_r4_ab_capture: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (ab_armed && !le_ab) |-> (b_o == $past(a_i)));

  a_r7_ab_enable: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe == oe_ab));

  a_r6_ba_transparent: assert property (@(posedge clk_ba) disable iff (!rst_n)
    le_ba |-> (a_o == b_i));

  a_r6_ba_capture: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (ba_armed && !le_ba) |-> (a_o == $past(b_i)));

  a_r8_ba_enable: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe == !oe_ba_n));

endmodule

bind xcvr_bidir xcvr_bidir_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n   (rst_n),
  .a_i     (a_i),
  .a_o     (a_o),
  .a_oe    (a_oe),
  .b_i     (b_i),
  .b_o     (b_o),
  .b_oe    (b_oe),
  .le_ab   (le_ab),
  .clk_ab  (clk_ab),
  .oe_ab   (oe_ab),
  .le_ba   (le_ba),
  .clk_ba  (clk_ba),
  .oe_ba_n (oe_ba_n)
);

// File: tb/xcvr_bidir_tb.sv
module xcvr_bidir_tb;

  localparam int W  = 36;
  localparam int VW = 2 * W + 4;
  localparam int NV = 11;

  localparam logic [W-1:0] D1 = 36'h1_2345_6789;
  localparam logic [W-1:0] D2 = 36'hF_0F0F_0F0F;
  localparam logic [W-1:0] D3 = 36'hA_AAAA_AAAA;
  localparam logic [W-1:0] D4 = 36'h5_5555_5555;
  localparam logic [W-1:0] D5 = 36'h8_0000_0001;
  localparam logic [W-1:0] ZZ = {W{1'bz}};

  // Row: {le, clk, oe(logical), data_in, expected_enable, expected_out}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, D1, 1'b1, D1},  // 0 transparent
    {1'b1, 1'b0, 1'b1, D2, 1'b1, D2},  // 1 transparent follows
    {1'b1, 1'b1, 1'b1, D2, 1'b1, D2},  // 2 edge while transparent
    {1'b1, 1'b0, 1'b1, D3, 1'b1, D3},  // 3 transparent
    {1'b0, 1'b0, 1'b1, D3, 1'b1, D3},  // 4 enable falls, word kept
    {1'b0, 1'b0, 1'b1, D4, 1'b1, D3},  // 5 hold, clock low
    {1'b0, 1'b0, 1'b0, D4, 1'b0, D3},  // 6 drive released
    {1'b0, 1'b1, 1'b0, D4, 1'b0, D4},  // 7 rising edge, released
    {1'b0, 1'b1, 1'b1, D5, 1'b1, D4},  // 8 hold, clock high
    {1'b0, 1'b0, 1'b1, D5, 1'b1, D4},  // 9 falling edge loads nothing
    {1'b0, 1'b1, 1'b1, D5, 1'b1, D5}   // 10 rising edge loads
  };
  localparam string TAG [NV] = '{"R2", "R2", "R5", "R2", "R5", "R3",
                                 "R7", "R9", "R3", "R4", "R4"};

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i, b_i;
  logic [W-1:0] a_o, b_o;
  logic         a_oe, b_oe;
  logic         le_ab, clk_ab, oe_ab;
  logic         le_ba, clk_ba, oe_ba_n;

  wire [W-1:0] a_pad = a_oe ? a_o : ZZ;
  wire [W-1:0] b_pad = b_oe ? b_o : ZZ;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  xcvr_bidir #(.WIDTH(W)) u_dut (
    .rst_n (rst_n), .a_i (a_i), .a_o (a_o), .a_oe (a_oe),
    .b_i (b_i), .b_o (b_o), .b_oe (b_oe),
    .le_ab (le_ab), .clk_ab (clk_ab), .oe_ab (oe_ab),
    .le_ba (le_ba), .clk_ba (clk_ba), .oe_ba_n (oe_ba_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // dir 0: A-to-B, dir 1: B-to-A; other_exp is the frozen opposite output
  task automatic apply_row(input int dir, input int idx, input logic [W-1:0] other_exp);
    logic [VW-1:0] v;
    logic le_v, clk_v, oe_v, eoe;
    logic [W-1:0] din, eout;
    string t;
    v     = VEC[idx];
    le_v  = v[2*W+3];
    clk_v = v[2*W+2];
    oe_v  = v[2*W+1];
    din   = v[2*W:W+1];
    eoe   = v[W];
    eout  = v[W-1:0];
    @(negedge clk);
    if (dir == 0) begin
      a_i = din; le_ab = le_v; oe_ab = oe_v;
      #2 clk_ab = clk_v;
      #2;
      t = $sformatf("%s AB row %0d", TAG[idx], idx);
      chk(t, b_o, eout);
      chk({"R7 ", t}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eoe});
      if (!eoe) chk({"R7 pad ", t}, b_pad, ZZ);
      chk({"R10 ", t}, a_o, other_exp);
    end else begin
      b_i = din; le_ba = le_v; oe_ba_n = ~oe_v;
      #2 clk_ba = clk_v;
      #2;
      t = $sformatf("R6 (%s) BA row %0d", TAG[idx], idx);
      chk(t, a_o, eout);
      chk({"R8 ", t}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eoe});
      if (!eoe) chk({"R8 pad ", t}, a_pad, ZZ);
      chk({"R10 ", t}, b_o, other_exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_i = D1; b_i = D2;
    le_ab = 1'b0; clk_ab = 1'b0; oe_ab = 1'b1;
    le_ba = 1'b0; clk_ba = 1'b0; oe_ba_n = 1'b0;
    #3;
    chk("R1 reset b_o", b_o, '0);
    chk("R1 reset a_o", a_o, '0);
    @(negedge clk) rst_n = 1'b1;
    #2;
    chk("R1 after release b_o", b_o, '0);
    chk("R1 after release a_o", a_o, '0);

    for (int i = 0; i < NV; i++) apply_row(0, i, '0);
    for (int i = 0; i < NV; i++) apply_row(1, i, D5);

    // R5: edge during transparency, then value at enable fall survives
    @(negedge clk);
    oe_ab = 1'b1; clk_ab = 1'b0; a_i = D1; le_ab = 1'b1;
    #2 clk_ab = 1'b1;
    #2 a_i = D2;
    #2 chk("R5 transparent after edge", b_o, D2);
    le_ab = 1'b0;
    #2 a_i = D3;
    #2 clk_ab = 1'b0;
    #2 chk("R5 word at enable fall kept", b_o, D2);
    clk_ab = 1'b1;
    #2 chk("R5 next rising edge loads", b_o, D3);

    // R9: transparent load on B-to-A while released, then driven
    @(negedge clk);
    oe_ba_n = 1'b1; b_i = D4; le_ba = 1'b1;
    #2 le_ba = 1'b0;
    #2 b_i = D1;
    #2 chk("R9 released enable", {{(W-1){1'b0}}, a_oe}, '0);
    oe_ba_n = 1'b0;
    #2 chk("R9 loaded while released", a_o, D4);
    chk("R10 AB unaffected", b_o, D3);

    // R1: reset in mid operation
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 mid reset b_o", b_o, '0);
    chk("R1 mid reset a_o", a_o, '0);
    @(negedge clk) rst_n = 1'b1;
    #2 chk("R1 held zero after release", b_o, '0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule